// File: doc/BRIEF.md
# Staggered-PRI Chirp Scheduler

This block paces the transmit side of a pulsed radar. A frame is built from three sub-frames, one after another: short chirps, then medium chirps, then long chirps. Each sub-frame has its own chirp width and its own pulse repetition interval (PRI). The three PRIs are offset from one another on purpose, so that a Doppler unfolder further down the chain can combine the three ambiguous velocity readings into one. In every PRI the block raises a chirp strobe for the configured width. It then opens a listen window that lasts until the PRI runs out. Alongside these it reports the sub-frame code, the chirp's position inside the frame, and single-cycle frame-start and frame-done pulses.

A two-bit mode request selects the trigger source. In autonomous scan mode, which is the mode out of reset, internal counters pace every chirp back to back and frames follow each other with no gap. In pass-through mode an external controller paces the chirps by flipping asynchronous toggle lines. Each flip of the trigger line starts one PRI. Flips of two further lines step an elevation counter and an azimuth counter. A change of mode request is honoured only at a frame boundary, so no frame is ever split between two modes.

Top module: `stagger_chirp_sched`

## Requirements
- R1: A frame holds 3 × CHIRPS_PER_SUB chirps (default 48). `chirp_idx` counts them from 0 to 3·CHIRPS_PER_SUB−1 and equals sub-frame code × CHIRPS_PER_SUB + the chirp's position inside its sub-frame.
- R2: Sub-frames run in a fixed order, and `sub_frame` carries the code of the one in progress: 0 = short, then 1 = medium, then 2 = long, then back to 0 for the next frame.
- R3: A PRI starts with `chirp_on` high for the sub-frame's chirp width in cycles. `listen_on` is then high for the rest of the PRI. The two are never high in the same cycle.
- R4: Each sub-frame uses its own width and PRI. The defaults are 100/17500 cycles (short), 500/16100 cycles (medium) and 3000/16700 cycles (long). Elaboration fails if two PRIs are equal or if a width is zero or not shorter than its PRI.
- R5: While reset is held, and in the first sampled cycle of reset, `active_mode` is 2'b01 and all strobes, `chirp_idx`, `elev_pos` and `azim_pos` are 0. With `mode_req` = 2'b01, the first chirp is high on the first clock edge after reset is released.
- R6: In autonomous mode (2'b01), PRIs follow each other without idle cycles and frames repeat back to back. The three toggle inputs change neither the timing nor the beam counters.
- R7: In pass-through mode (2'b00), every edge of `trig_tgl`, rising or falling, passes a two-flop synchronizer and starts one PRI. `chirp_on` goes high on the third clock edge after the input changes. A trigger edge that arrives while a PRI is running is dropped. Between PRIs, `chirp_on` and `listen_on` stay low.
- R8: In pass-through mode, every edge of `elev_tgl` or `azim_tgl` advances `elev_pos` or `azim_pos` by one, wrapping to 0 after ELEV_POS−1 or AZIM_POS−1.
- R9: `frame_start` is high only in the first cycle of chirp 0. `frame_done` is high only in the final cycle of the last long PRI.
- R10: `mode_req` is adopted into `active_mode` only at a frame boundary. A boundary is the cycle `frame_done` is high, or an idle cycle with `chirp_idx` = 0. Codes 2'b10 and 2'b11 keep the scheduler idle and ignore triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested mode: 00 pass-through, 01 autonomous, 10/11 idle |
| trig_tgl | input | 1 | Asynchronous chirp trigger toggle (pass-through) |
| elev_tgl | input | 1 | Asynchronous elevation step toggle (pass-through) |
| azim_tgl | input | 1 | Asynchronous azimuth step toggle (pass-through) |
| chirp_on | output | 1 | Chirp active strobe |
| listen_on | output | 1 | Receive window after the chirp |
| sub_frame | output | 2 | Current sub-frame code |
| chirp_idx | output | $clog2(3·CHIRPS_PER_SUB) | Chirp position in the frame |
| frame_start | output | 1 | One-cycle pulse at the first short chirp |
| frame_done | output | 1 | One-cycle pulse at the end of the last long PRI |
| active_mode | output | 2 | Mode in force |
| elev_pos | output | $clog2(ELEV_POS) | Elevation step counter |
| azim_pos | output | $clog2(AZIM_POS) | Azimuth step counter |

## Verification
The interesting collision is a mode request meeting the cycle that closes a frame. `frame_done` and mode adoption fall on the same edge, and that edge also decides whether the next PRI is launched. The bench provokes this by changing `mode_req` in the middle of a running autonomous frame and holding it there. It checks every cycle that the old frame finishes unchanged up to and including its `frame_done` cycle. It then checks that the very next cycle already shows the new mode, with both strobes low. A second collision is also provoked: a trigger edge that lands while a pass-through PRI is still counting. The bench judges it by confirming that no extra PRI appears afterwards.

// File: rtl/chirp_sched_pkg.sv
package chirp_sched_pkg;
   localparam logic [1:0] SF_SHORT  = 2'd0;
   localparam logic [1:0] SF_MEDIUM = 2'd1;
   localparam logic [1:0] SF_LONG   = 2'd2;

   localparam logic [1:0] MODE_PASS = 2'b00;
   localparam logic [1:0] MODE_AUTO = 2'b01;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
   parameter int unsigned LANES  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] tgl_in,
   output logic [LANES-1:0] evt
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cs_edge_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // STAGES synchronizer flops plus one history flop for edge detection
      logic [STAGES:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-1:0], tgl_in[i]};
      end
      assign evt[i] = sh_q[STAGES] ^ sh_q[STAGES-1];
   end
endmodule

// File: rtl/cs_beam_count.sv
module cs_beam_count #(
   parameter int unsigned MOD = 16,
   localparam int unsigned PW = $clog2(MOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [PW-1:0] pos
);
   if (MOD < 2) begin : g_bad_mod
      $error("cs_beam_count: MOD must be at least 2");
   end

   logic [PW-1:0] pos_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pos_q <= '0;
      else if (inc)   pos_q <= (pos_q == PW'(MOD - 1)) ? '0 : pos_q + 1'b1;
   end
   assign pos = pos_q;

   AST_BEAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(pos_q)); // R6
endmodule

// File: rtl/cs_profile.sv
module cs_profile import chirp_sched_pkg::*; #(
   parameter int unsigned CNT_W       = 15,
   parameter int unsigned SHORT_CHIRP = 100,
   parameter int unsigned SHORT_PRI   = 17500,
   parameter int unsigned MED_CHIRP   = 500,
   parameter int unsigned MED_PRI     = 16100,
   parameter int unsigned LONG_CHIRP  = 3000,
   parameter int unsigned LONG_PRI    = 16700
) (
   input  logic [1:0]       sf,
   output logic [CNT_W-1:0] chirp_len,
   output logic [CNT_W-1:0] pri_len
);
   // staggered PRIs must stay mutually distinct
   if (SHORT_PRI == MED_PRI || MED_PRI == LONG_PRI || SHORT_PRI == LONG_PRI) begin : g_bad_pri
      $error("cs_profile: PRIs must be distinct");
   end
   if (SHORT_CHIRP == 0 || SHORT_CHIRP >= SHORT_PRI) begin : g_bad_short
      $error("cs_profile: short width out of range");
   end
   if (MED_CHIRP == 0 || MED_CHIRP >= MED_PRI) begin : g_bad_med
      $error("cs_profile: medium width out of range");
   end
   if (LONG_CHIRP == 0 || LONG_CHIRP >= LONG_PRI) begin : g_bad_long
      $error("cs_profile: long width out of range");
   end
   if (max3(SHORT_PRI, MED_PRI, LONG_PRI) >= (64'd1 << CNT_W)) begin : g_bad_cnt
      $error("cs_profile: CNT_W too narrow");
   end

   always_comb begin
      unique case (sf)
         SF_SHORT: begin
            chirp_len = CNT_W'(SHORT_CHIRP);
            pri_len   = CNT_W'(SHORT_PRI);
         end
         SF_MEDIUM: begin
            chirp_len = CNT_W'(MED_CHIRP);
            pri_len   = CNT_W'(MED_PRI);
         end
         default: begin
            chirp_len = CNT_W'(LONG_CHIRP);
            pri_len   = CNT_W'(LONG_PRI);
         end
      endcase
   end
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl import chirp_sched_pkg::*; #(
   parameter int unsigned N_SUB       = 16,
   parameter int unsigned SHORT_CHIRP = 100,
   parameter int unsigned SHORT_PRI   = 17500,
   parameter int unsigned MED_CHIRP   = 500,
   parameter int unsigned MED_PRI     = 16100,
   parameter int unsigned LONG_CHIRP  = 3000,
   parameter int unsigned LONG_PRI    = 16700,
   localparam int unsigned FR_W  = $clog2(3 * N_SUB),
   localparam int unsigned SUB_W = (N_SUB > 1) ? $clog2(N_SUB) : 1,
   localparam int unsigned CNT_W = $clog2(max3(SHORT_PRI, MED_PRI, LONG_PRI) + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_req,
   input  logic            trig_evt,
   output logic            chirp_on,
   output logic            listen_on,
   output logic [1:0]      sub_frame,
   output logic [FR_W-1:0] chirp_idx,
   output logic            frame_start,
   output logic            frame_done,
   output logic [1:0]      active_mode
);
   if (N_SUB < 1) begin : g_bad_nsub
      $error("cs_seq_ctrl: N_SUB must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [1:0]       sf_q;
   logic [SUB_W-1:0] sub_q;
   logic [FR_W-1:0]  fr_q;
   logic [1:0]       mode_q;

   logic [CNT_W-1:0] chirp_len, pri_len;

   cs_profile #(
      .CNT_W(CNT_W),
      .SHORT_CHIRP(SHORT_CHIRP), .SHORT_PRI(SHORT_PRI),
      .MED_CHIRP(MED_CHIRP),     .MED_PRI(MED_PRI),
      .LONG_CHIRP(LONG_CHIRP),   .LONG_PRI(LONG_PRI)
   ) u_profile (
      .sf(sf_q), .chirp_len(chirp_len), .pri_len(pri_len)
   );

   logic       pri_end, last_in_sub, frame_end, at_rest, boundary;
   logic       launch, keep;
   logic [1:0] next_mode;

   assign pri_end     = busy_q && (cnt_q == pri_len - 1'b1);
   assign last_in_sub = (sub_q == SUB_W'(N_SUB - 1));
   assign frame_end   = pri_end && last_in_sub && (sf_q == SF_LONG);
   assign at_rest     = !busy_q && (fr_q == '0);
   assign boundary    = at_rest || frame_end;
   assign next_mode   = boundary ? mode_req : mode_q;
   assign launch      = !busy_q && ((next_mode == MODE_AUTO) ||
                                    ((next_mode == MODE_PASS) && trig_evt));
   assign keep        = (next_mode == MODE_AUTO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         sf_q   <= SF_SHORT;
         sub_q  <= '0;
         fr_q   <= '0;
         mode_q <= MODE_AUTO;
      end else begin
         mode_q <= next_mode;
         if (pri_end) begin
            cnt_q  <= '0;
            busy_q <= keep;
            fr_q   <= frame_end ? '0 : fr_q + 1'b1;
            if (last_in_sub) begin
               sub_q <= '0;
               sf_q  <= (sf_q == SF_LONG) ? SF_SHORT : sf_q + 1'b1;
            end else begin
               sub_q <= sub_q + 1'b1;
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end

   assign chirp_on    = busy_q && (cnt_q < chirp_len);
   assign listen_on   = busy_q && (cnt_q >= chirp_len);
   assign sub_frame   = sf_q;
   assign chirp_idx   = fr_q;
   assign frame_start = busy_q && (fr_q == '0) && (cnt_q == '0);
   assign frame_done  = frame_end;
   assign active_mode = mode_q;

   AST_SF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_q != $past(sf_q)) |-> (sf_q == (($past(sf_q) == SF_LONG) ? SF_SHORT : $past(sf_q) + 2'd1))); // R2
   AST_FIDX_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fr_q) == int'(sf_q) * int'(N_SUB) + int'(sub_q)); // R1
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && cnt_q != '0) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
   AST_LISTEN_AFTER_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(listen_on) |-> $past(chirp_on)); // R3
   AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> (fr_q == '0)); // R10
   AST_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[1] |-> !busy_q); // R10
endmodule

// File: rtl/stagger_chirp_sched.sv
module stagger_chirp_sched import chirp_sched_pkg::*; #(
   parameter int unsigned CHIRPS_PER_SUB = 16,
   parameter int unsigned SHORT_CHIRP    = 100,
   parameter int unsigned SHORT_PRI      = 17500,
   parameter int unsigned MED_CHIRP      = 500,
   parameter int unsigned MED_PRI        = 16100,
   parameter int unsigned LONG_CHIRP     = 3000,
   parameter int unsigned LONG_PRI       = 16700,
   parameter int unsigned ELEV_POS       = 31,
   parameter int unsigned AZIM_POS       = 16,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [1:0]                            mode_req,
   input  logic                                  trig_tgl,
   input  logic                                  elev_tgl,
   input  logic                                  azim_tgl,
   output logic                                  chirp_on,
   output logic                                  listen_on,
   output logic [1:0]                            sub_frame,
   output logic [$clog2(3*CHIRPS_PER_SUB)-1:0]   chirp_idx,
   output logic                                  frame_start,
   output logic                                  frame_done,
   output logic [1:0]                            active_mode,
   output logic [$clog2(ELEV_POS)-1:0]           elev_pos,
   output logic [$clog2(AZIM_POS)-1:0]           azim_pos
);
   localparam int unsigned LANE_TRIG = 0;
   localparam int unsigned LANE_ELEV = 1;
   localparam int unsigned LANE_AZIM = 2;

   logic [2:0] evt;
   logic       pass_mode;

   cs_edge_sync #(.LANES(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .tgl_in({azim_tgl, elev_tgl, trig_tgl}),
      .evt(evt)
   );

   cs_seq_ctrl #(
      .N_SUB(CHIRPS_PER_SUB),
      .SHORT_CHIRP(SHORT_CHIRP), .SHORT_PRI(SHORT_PRI),
      .MED_CHIRP(MED_CHIRP),     .MED_PRI(MED_PRI),
      .LONG_CHIRP(LONG_CHIRP),   .LONG_PRI(LONG_PRI)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .mode_req(mode_req),
      .trig_evt(evt[LANE_TRIG]),
      .chirp_on(chirp_on), .listen_on(listen_on),
      .sub_frame(sub_frame), .chirp_idx(chirp_idx),
      .frame_start(frame_start), .frame_done(frame_done),
      .active_mode(active_mode)
   );

   assign pass_mode = (active_mode == MODE_PASS);

   cs_beam_count #(.MOD(ELEV_POS)) u_elev (
      .clk(clk), .rst_n(rst_n),
      .inc(evt[LANE_ELEV] && pass_mode),
      .pos(elev_pos)
   );

   cs_beam_count #(.MOD(AZIM_POS)) u_azim (
      .clk(clk), .rst_n(rst_n),
      .inc(evt[LANE_AZIM] && pass_mode),
      .pos(azim_pos)
   );

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(chirp_on && listen_on)); // R3
   AST_DONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (chirp_idx == '0)); // R9
endmodule

// File: tb/stagger_chirp_sched_bench.sv
`timescale 1ns/1ps
module stagger_chirp_sched_bench;
   localparam int N  = 2;
   localparam int PRI_T [3] = '{7, 5, 9};
   localparam int WID_T [3] = '{2, 3, 4};
   localparam int FL = N * (7 + 5 + 9);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_req = 2'b01;
   logic       trig_tgl = 1'b0, elev_tgl = 1'b0, azim_tgl = 1'b0;
   logic       chirp_on, listen_on, frame_start, frame_done;
   logic [1:0] sub_frame, active_mode;
   logic [2:0] chirp_idx;
   logic [1:0] elev_pos, azim_pos;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   stagger_chirp_sched #(
      .CHIRPS_PER_SUB(N),
      .SHORT_CHIRP(2), .SHORT_PRI(7),
      .MED_CHIRP(3),   .MED_PRI(5),
      .LONG_CHIRP(4),  .LONG_PRI(9),
      .ELEV_POS(3),    .AZIM_POS(4),
      .SYNC_STAGES(2)
   ) u_stagger_chirp_sched (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
      .trig_tgl(trig_tgl), .elev_tgl(elev_tgl), .azim_tgl(azim_tgl),
      .chirp_on(chirp_on), .listen_on(listen_on),
      .sub_frame(sub_frame), .chirp_idx(chirp_idx),
      .frame_start(frame_start), .frame_done(frame_done),
      .active_mode(active_mode), .elev_pos(elev_pos), .azim_pos(azim_pos)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // expected {chirp, listen, sub_frame, chirp_idx, frame_start, frame_done} at frame offset f
   function automatic logic [8:0] exp_at(input int f);
      int rem;
      logic [8:0] v;
      rem = f;
      v = '0;
      for (int s = 0; s < 3; s++) begin
         for (int k = 0; k < N; k++) begin
            if (rem >= 0 && rem < PRI_T[s])
               v = {rem < WID_T[s], rem >= WID_T[s], 2'(s), 3'(s * N + k),
                    (s == 0 && k == 0 && rem == 0),
                    (s == 2 && k == N - 1 && rem == PRI_T[s] - 1)};
            rem -= PRI_T[s];
         end
      end
      return v;
   endfunction

   function automatic int frame_off(input int k);
      int off;
      off = 0;
      for (int j = 0; j < k; j++) off += PRI_T[j / N];
      return off;
   endfunction

   function automatic logic [31:0] obs();
      return 32'({chirp_on, listen_on, sub_frame, chirp_idx, frame_start, frame_done});
   endfunction

   // one pass-through PRI for frame chirp k; optional extra trigger edge mid-PRI
   task automatic pass_chirp(input int k, input bit drop);
      trig_tgl = ~trig_tgl;
      tick(); check("R7 sync stage 1 idle", 32'({chirp_on, listen_on}), 32'd0);
      tick(); check("R7 sync stage 2 idle", 32'({chirp_on, listen_on}), 32'd0);
      for (int c = 0; c < PRI_T[k / N]; c++) begin
         tick();
         check("R1/R2/R3/R7/R9 pass PRI", obs(), 32'(exp_at(frame_off(k) + c)));
         if (drop && c == 0) trig_tgl = ~trig_tgl;
      end
      tick(); check("R7 idle after PRI", 32'({chirp_on, listen_on}), 32'd0);
      if (drop) begin
         for (int i = 0; i < 3; i++) begin
            tick(); check("R7 dropped edge gives no PRI", 32'({chirp_on, listen_on}), 32'd0);
         end
      end
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R5: reset state
      tick(); tick(); tick();
      check("R5 reset strobes", 32'({chirp_on, listen_on, frame_start, frame_done}), 32'd0);
      check("R5 reset mode", 32'(active_mode), 32'd1);
      check("R5 reset chirp_idx", 32'(chirp_idx), 32'd0);
      check("R5 reset beam", 32'({elev_pos, azim_pos}), 32'd0);
      rst_n = 1'b1;

      // R6: two autonomous frames back to back, toggles ignored; R10 request mid frame
      for (int f = 0; f < 2 * FL; f++) begin
         tick();
         check("R1/R2/R3/R4/R6/R9 auto sweep", obs(), 32'(exp_at(f % FL)));
         if (f < 70 && (f % 4) == 1) begin
            trig_tgl = ~trig_tgl;
            elev_tgl = ~elev_tgl;
            azim_tgl = ~azim_tgl;
         end
         if (f == 60) mode_req = 2'b00;
      end
      // R10: new mode in force one cycle after frame_done, scheduler idle
      tick();
      check("R10 mode adopted at frame end", 32'(active_mode), 32'd0);
      check("R10 idle after switch", 32'({chirp_on, listen_on, chirp_idx}), 32'd0);
      check("R6 beam counters untouched in auto", 32'({elev_pos, azim_pos}), 32'd0);

      // R7: pass-through chirps
      pass_chirp(0, 1'b0);
      pass_chirp(1, 1'b1);

      // R10: request mid frame is not adopted
      mode_req = 2'b01;
      for (int i = 0; i < 4; i++) tick();
      check("R10 no mid-frame switch", 32'(active_mode), 32'd0);
      check("R10 no autonomous chirp mid frame", 32'({chirp_on, listen_on}), 32'd0);
      mode_req = 2'b00;

      // R8: beam counters in pass-through (4 elev edges mod 3, 5 azim edges mod 4)
      for (int i = 0; i < 5; i++) begin
         if (i < 4) elev_tgl = ~elev_tgl;
         azim_tgl = ~azim_tgl;
         tick(); tick();
      end
      for (int i = 0; i < 4; i++) tick();
      check("R8 elevation wrap", 32'(elev_pos), 32'd1);
      check("R8 azimuth wrap", 32'(azim_pos), 32'd1);

      for (int k = 2; k < 3 * N; k++) pass_chirp(k, 1'b0);
      check("R9 frame index wraps", 32'(chirp_idx), 32'd0);

      // R10: idle mode ignores triggers
      mode_req = 2'b10;
      tick(); tick();
      check("R10 idle mode adopted", 32'(active_mode), 32'd2);
      trig_tgl = ~trig_tgl;
      for (int i = 0; i < 5; i++) begin
         tick();
         check("R10 idle mode ignores trigger", 32'({chirp_on, listen_on}), 32'd0);
      end

      // R6/R10: back to autonomous from rest
      mode_req = 2'b01;
      for (int f = 0; f < FL; f++) begin
         tick();
         check("R1/R2/R3/R6/R9 auto restart", obs(), 32'(exp_at(f)));
      end
      check("R10 auto mode in force", 32'(active_mode), 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule